// File: doc/BRIEF.md
# Bus-to-Device Four-Phase Handshake Controller

This clocked controller sits between a bus master and a local device and runs a four-phase handshake on each side. The master raises either a read request or a write request. The controller answers on its bus acknowledge output. On the device side it drives a strobe and waits for the device acknowledge. It also drives an enable to an external data transceiver. The enable is placed after the device has answered on reads, and before the strobe on writes. On the return-to-zero phase of both cycle types, the bus acknowledge and the strobe drop together.

The three asynchronous inputs pass through two-flop synchronisers before the sequencing FSM sees them. Every output comes straight from a register. The FSM decides between a read and a write only while idle. It refuses to start a new cycle while the device acknowledge from the previous cycle is still high. Protocol violations set a sticky error flag, and only reset clears it.

Top module: `hs_bridge_ctrl`

## Requirements
- R1: A synchronous active-high reset drives bus acknowledge, strobe, transceiver enable and error low and returns the FSM to idle.
- R2: While idle, with the device acknowledge low and only the read request high, the controller raises the strobe and keeps the transceiver enable and bus acknowledge low.
- R3: In a read, once the device acknowledge rises, the transceiver enable rises first, and the bus acknowledge rises exactly one clock later. The strobe stays high throughout.
- R4: In a read, once the read request falls, the transceiver enable falls first. One clock later, the bus acknowledge and the strobe fall in the same clock.
- R5: While idle, with the device acknowledge low and only the write request high, the transceiver enable rises first, and the strobe rises one clock later.
- R6: In a write, once the device acknowledge rises, the transceiver enable falls first, and the bus acknowledge rises one clock later. The strobe stays high.
- R7: In a write, once the write request falls, the bus acknowledge and the strobe fall in the same clock.
- R8: A request seen while idle with the device acknowledge still high does not start a cycle, and it sets the error flag. The cycle starts once the acknowledge is low.
- R9: Read and write requests that are both high while idle start no cycle and set the error flag.
- R10: The opposite request rising during a cycle sets the error flag and leaves that cycle's outputs unchanged.
- R11: The error flag stays high until reset.
- R12: A change on a request or acknowledge input reaches the outputs on the third rising clock edge after it is applied: two synchroniser stages plus the output register.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_i | input | 1 | Master read request (asynchronous) |
| wr_req_i | input | 1 | Master write request (asynchronous) |
| dev_ack_i | input | 1 | Device acknowledge (asynchronous) |
| bus_ack_o | output | 1 | Acknowledge to the master |
| dev_stb_o | output | 1 | Strobe to the device |
| xcvr_en_o | output | 1 | Data transceiver enable |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The embedded properties assume that the environment keeps to the four-phase protocol. Each request stays high until the bus acknowledge answers it. The device acknowledge only follows the strobe. The ordering checks for bus acknowledge and enable edges rely on this. The stimulus changes a single input at a time and waits longer than the synchroniser latency between changes. The exceptions are the deliberate violations, where both requests rise together or a request arrives with the device acknowledge still high. In those cases the properties still hold, because the controller holds its current state.

// File: rtl/hs_bridge_pkg.sv
package hs_bridge_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_STB,
        S_RD_XEN,
        S_RD_ACK,
        S_RD_XOFF,
        S_WR_XEN,
        S_WR_STB,
        S_WR_XOFF,
        S_WR_ACK,
        S_RTZ
    } hs_state_e;

    typedef struct packed {
        hs_state_e st;
        logic      stb;
        logic      xen;
        logic      back;
        logic      err;
    } hs_regs_t;

    function automatic logic is_read_state(input hs_state_e s);
        return (s == S_RD_STB) || (s == S_RD_XEN) || (s == S_RD_ACK) || (s == S_RD_XOFF);
    endfunction

    function automatic logic is_write_state(input hs_state_e s);
        return (s == S_WR_XEN) || (s == S_WR_STB) || (s == S_WR_XOFF) || (s == S_WR_ACK);
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
    import hs_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_s,
    input  logic wr_s,
    input  logic ack_s,
    output logic back_o,
    output logic stb_o,
    output logic xen_o,
    output logic err_o
);
    hs_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.err = r_q.err;
        unique case (r_q.st)
            S_IDLE: begin
                if (rd_s && wr_s) begin
                    r_d.err = 1'b1;
                end else if ((rd_s || wr_s) && ack_s) begin
                    r_d.err = 1'b1;
                end else if (rd_s) begin
                    r_d.st = S_RD_STB;
                end else if (wr_s) begin
                    r_d.st = S_WR_XEN;
                end
            end
            S_RD_STB:  if (ack_s) r_d.st = S_RD_XEN;
            S_RD_XEN:  r_d.st = S_RD_ACK;
            S_RD_ACK:  if (!rd_s) r_d.st = S_RD_XOFF;
            S_RD_XOFF: r_d.st = S_RTZ;
            S_WR_XEN:  r_d.st = S_WR_STB;
            S_WR_STB:  if (ack_s) r_d.st = S_WR_XOFF;
            S_WR_XOFF: r_d.st = S_WR_ACK;
            S_WR_ACK:  if (!wr_s) r_d.st = S_RTZ;
            S_RTZ:     r_d.st = S_IDLE;
            default:   r_d.st = S_IDLE;
        endcase

        if ((is_read_state(r_q.st) && wr_s) || (is_write_state(r_q.st) && rd_s)) begin
            r_d.err = 1'b1;
        end

        r_d.stb  = (r_d.st == S_RD_STB) || (r_d.st == S_RD_XEN) || (r_d.st == S_RD_ACK) ||
                   (r_d.st == S_RD_XOFF) || (r_d.st == S_WR_STB) || (r_d.st == S_WR_XOFF) ||
                   (r_d.st == S_WR_ACK);
        r_d.xen  = (r_d.st == S_RD_XEN) || (r_d.st == S_RD_ACK) ||
                   (r_d.st == S_WR_XEN) || (r_d.st == S_WR_STB);
        r_d.back = (r_d.st == S_RD_ACK) || (r_d.st == S_RD_XOFF) || (r_d.st == S_WR_ACK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: S_IDLE, stb: 1'b0, xen: 1'b0, back: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign back_o = r_q.back;
    assign stb_o  = r_q.stb;
    assign xen_o  = r_q.xen;
    assign err_o  = r_q.err;

    // R1: idle keeps every handshake output low
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == S_IDLE) |-> !(r_q.stb || r_q.xen || r_q.back));

    // R3, R6: bus acknowledge is only held while the strobe is held
    a_r3_back_under_stb: assert property (@(posedge clk) disable iff (rst)
        r_q.back |-> r_q.stb);

    // R3: on a read the enable is already up a cycle before the bus acknowledge
    a_r3_read_xen_first: assert property (@(posedge clk) disable iff (rst)
        ($rose(r_q.back) && r_q.xen) |-> $past(r_q.xen));

    // R6: on a write the enable has dropped before the bus acknowledge
    a_r6_write_xen_off: assert property (@(posedge clk) disable iff (rst)
        ($rose(r_q.back) && !r_q.xen) |-> $past(r_q.stb) && !$past(r_q.xen));

    // R5: on a write the enable leads the strobe
    a_r5_write_xen_lead: assert property (@(posedge clk) disable iff (rst)
        ($rose(r_q.stb) && r_q.xen) |-> $past(r_q.xen));

    // R4, R7: return to zero drops acknowledge and strobe in one clock
    a_r7_rtz_together: assert property (@(posedge clk) disable iff (rst)
        $fell(r_q.back) |-> $fell(r_q.stb));

    // R11: error flag is sticky
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        r_q.err |=> r_q.err);

    // R8: no strobe or enable leaves idle while the device still acknowledges
    a_r8_hold_off: assert property (@(posedge clk) disable iff (rst)
        ((r_q.st == S_IDLE) && ack_s) |=> (r_q.st == S_IDLE) || $past(!ack_s));

endmodule

// File: rtl/hs_bridge_ctrl.sv
module hs_bridge_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_req_i,
    input  logic wr_req_i,
    input  logic dev_ack_i,
    output logic bus_ack_o,
    output logic dev_stb_o,
    output logic xcvr_en_o,
    output logic proto_err_o
);
    localparam int NUM_IN = 3;

    logic [NUM_IN-1:0] in_async, in_sync;

    assign in_async = {rd_req_i, wr_req_i, dev_ack_i};

    hs_sync #(
        .WIDTH  (NUM_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (in_async),
        .sync_o  (in_sync)
    );

    hs_seq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .rd_s   (in_sync[2]),
        .wr_s   (in_sync[1]),
        .ack_s  (in_sync[0]),
        .back_o (bus_ack_o),
        .stb_o  (dev_stb_o),
        .xen_o  (xcvr_en_o),
        .err_o  (proto_err_o)
    );

endmodule

// File: tb/hs_bridge_ctrl_tb.sv
`timescale 1ns/1ps
module hs_bridge_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
    logic back, stb, xen, err;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hs_bridge_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .rd_req_i    (rd),
        .wr_req_i    (wr),
        .dev_ack_i   (ack),
        .bus_ack_o   (back),
        .dev_stb_o   (stb),
        .xcvr_en_o   (xen),
        .proto_err_o (err)
    );

    // {rd, wr, ack, exp_back, exp_stb, exp_xen, exp_err}
    localparam int NV = 14;
    localparam logic [6:0] VEC [NV] = '{
        7'b100_0100, // R2 read start
        7'b101_1110, // R3 device answers, enable and bus ack up
        7'b001_0000, // R4 read request drops, return to zero
        7'b000_0000, // R4 device releases
        7'b010_0110, // R5 write start, enable and strobe up
        7'b011_1100, // R6 device answers, enable off, bus ack up
        7'b001_0000, // R7 write request drops
        7'b000_0000, // R7 device releases
        7'b001_0000, // R8 stale acknowledge while idle
        7'b101_0001, // R8 request held off, error set
        7'b100_0101, // R8 read starts once acknowledge low
        7'b101_1111, // R11 error stays during normal cycle
        7'b001_0001, // R11
        7'b000_0001  // R11
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {back, stb, xen, err};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {back,stb,xen,err} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rd = 0; wr = 0; ack = 0;
        rst = 1;
        step(3);
        rst = 0;
    endtask

    initial begin
        do_reset();
        step(1);
        check("R1 after reset", 4'b0000);

        for (int i = 0; i < NV; i++) begin
            {rd, wr, ack} = VEC[i][6:4];
            step(8);
            check($sformatf("table row %0d (R2-R11 sequence)", i), VEC[i][3:0]);
        end

        // R1, R11: reset clears the sticky error
        do_reset();
        step(1);
        check("R1 R11 reset clears error", 4'b0000);

        // R12 and R2: latency of the read start
        rd = 1;
        step(2);
        check("R12 no change after two edges", 4'b0000);
        step(1);
        check("R12 R2 strobe on third edge", 4'b0100);
        // R3 ordering
        ack = 1;
        step(3);
        check("R3 enable before bus ack", 4'b0110);
        step(1);
        check("R3 bus ack one clock later", 4'b1110);
        // R4 ordering
        rd = 0;
        step(3);
        check("R4 enable falls first", 4'b1100);
        step(1);
        check("R4 bus ack and strobe fall together", 4'b0000);
        ack = 0;
        step(4);

        // R5 ordering
        wr = 1;
        step(3);
        check("R5 enable leads", 4'b0010);
        step(1);
        check("R5 strobe follows", 4'b0110);
        // R6 ordering
        ack = 1;
        step(3);
        check("R6 enable off", 4'b0100);
        step(1);
        check("R6 bus ack rises", 4'b1100);
        // R7
        wr = 0;
        step(2);
        check("R7 still held", 4'b1100);
        step(1);
        check("R7 bus ack and strobe fall together", 4'b0000);
        ack = 0;
        step(4);

        // R10: read request during a write
        wr = 1;
        step(5);
        check("R10 write waiting", 4'b0110);
        rd = 1;
        step(5);
        check("R10 error, write outputs unchanged", 4'b0111);
        rd = 0;
        ack = 1;
        step(5);
        check("R10 write continues", 4'b1101);
        wr = 0; ack = 0;
        step(6);
        check("R11 error held after cycle", 4'b0001);

        // R9: both requests at once
        do_reset();
        rd = 1; wr = 1;
        step(6);
        check("R9 no cycle, error set", 4'b0001);
        rd = 0; wr = 0;
        step(4);
        check("R11 error held while idle", 4'b0001);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule